// File: doc/BRIEF.md
# NAND Flash Primitive Bus Engine

This block sits between an on-chip bus and an 8-bit NAND flash device. Each operation runs one primitive on the flash bus: a command cycle, an address cycle, a sector write from internal RAM to the flash, a sector read from the flash into internal RAM, or a single status read. Software builds page reads, programs and erases by issuing these primitives one after another. It polls a completion flag between them.

The bus side sees a byte-addressed window. At the bottom is a sector RAM with `NBUF` main buffers of `SECT` bytes each, followed by the same number of spare areas of `SPARE` bytes each. The register file sits at byte offset 0xE00. The bus is 16 bits wide and little-endian: the low byte sits at the even address. A control register starts operations and reports their completion. The flash pins are driven from the engine's state. Every write or read strobe stays low for `STROBE_CYC` clock cycles and then high for `STROBE_CYC` clock cycles.

Top module: `nand_prim_engine`

## Requirements
- R1: After reset the done flag (control bit 15) reads 1 and all other control bits read 0. CE#, WE# and RE# are high, CLE and ALE are low, and the I/O output enable is low.
- R2: Writing control with bit 0 set runs a command cycle. CE# goes low and CLE goes high. The low byte of the command register (offset 0xE08) is driven on I/O with the output enable high, and WE# pulses exactly once. The done flag reads 0 from the cycle after the write until the operation ends.
- R3: Control bit 1 runs an address cycle. ALE is high and CLE is low, the low 8 bits of the address register (offset 0xE06) are driven on I/O, and WE# pulses exactly once. CLE and ALE are never high together.
- R4: Control bit 2 runs a data input of `SECT+SPARE` bytes, one WE# pulse per byte, with CLE and ALE low. The selected main buffer goes out first, in ascending address order. The selected spare area follows. Main buffer b sits at byte b*SECT and spare area b at NBUF*SECT + b*SPARE.
- R5: Control bit 3 runs a data output. No RE# pulse occurs while R/B# is low. After R/B# goes high, `SECT+SPARE` RE# pulses follow. The I/O value present in the last low cycle of each pulse is stored, main bytes first and then spare bytes, into the pair picked by the buffer-select register (offset 0xE04, 2 bits, reads back masked).
- R6: Control bit 5 runs a status read: one RE# pulse. The captured byte goes to byte address 0x000, the low byte of main buffer 0, whatever the buffer select. Byte 0x001 is not changed.
- R7: If several trigger bits are written together, only the highest-priority one runs. Priority from highest to lowest is bit 0, bit 1, bit 2, bit 3, bit 5. A control write with none of these bits set, other than 0x8000, starts nothing.
- R8: A trigger written while an operation is running is ignored. The running operation finishes with its own pulse count and pin values.
- R9: Writing exactly 0x8000 to control (offset 0xE1C) abandons any running operation. In the cycle after the write, the done flag reads 1, CE# is high and no strobe is low. No further strobes follow.
- R10: Every RAM word and every register reads back what was written through the bus at the addresses given in R2 to R6.
- R11: Every WE# or RE# low phase lasts exactly `STROBE_CYC` cycles and occurs with CE# low. During a command or address pulse the I/O value stays stable. A single-byte operation sets the done flag exactly 2*`STROBE_CYC` cycles after the write that started it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address into RAM or register window |
| bus_we | input | 1 | Write strobe for one 16-bit word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| fl_ce_n | output | 1 | Flash chip enable, low while an operation runs |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Flash write strobe |
| fl_re_n | output | 1 | Flash read strobe |
| fl_io_oe | output | 1 | High when the engine drives the I/O bus |
| fl_io_out | output | 8 | I/O bus value driven to the flash |
| fl_io_in | input | 8 | I/O bus value from the flash |
| fl_rb_n | input | 1 | Ready/busy from the flash, low while busy |

## Verification
Stale sequencer state shows up within one strobe period at the pins. A wrong byte index, sector offset or held-over operation code gives a wrong byte count or a wrong byte on I/O, and the bench flash model records every pulse. A wrong capture address only shows after the operation ends, when the bus reads back the sector. For that reason each buffer is read back in full after every data output and status read. A broken abort or busy lock changes the done flag in the very next cycle, or adds extra pulses within the following strobe periods.

// File: rtl/nand_eng_pkg.sv
`timescale 1ns/1ps
package nand_eng_pkg;

    localparam int BUS_AW = 12;

    // register window
    localparam logic [BUS_AW-1:0] REG_BASE   = 12'hE00;
    localparam logic [4:0]        OFS_BUFSEL = 5'h04;
    localparam logic [4:0]        OFS_ADDR   = 5'h06;
    localparam logic [4:0]        OFS_CMD    = 5'h08;
    localparam logic [4:0]        OFS_CTRL   = 5'h1C;

    localparam logic [15:0] CLEAR_WORD = 16'h8000;
    localparam int          DONE_BIT   = 15;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CMD,
        OP_ADDR,
        OP_DIN,
        OP_DOUT,
        OP_STAT
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAITRB,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        logic       ce_n;
        logic       cle;
        logic       ale;
        logic       we_n;
        logic       re_n;
        logic       io_oe;
        logic [7:0] io;
    } pins_t;

    // trig = {bit5, bit3, bit2, bit1, bit0} of the control word
    function automatic op_e decode_trigger(input logic [4:0] trig);
        if (trig[0])      return OP_CMD;
        else if (trig[1]) return OP_ADDR;
        else if (trig[2]) return OP_DIN;
        else if (trig[3]) return OP_DOUT;
        else if (trig[4]) return OP_STAT;
        else              return OP_NONE;
    endfunction

    function automatic logic is_write_op(input op_e op);
        return (op == OP_CMD) || (op == OP_ADDR) || (op == OP_DIN);
    endfunction

    function automatic logic is_read_op(input op_e op);
        return (op == OP_DOUT) || (op == OP_STAT);
    endfunction

endpackage

// File: rtl/nand_buf_ram.sv
`timescale 1ns/1ps
module nand_buf_ram #(
    parameter int TOTAL = 2112
) (
    input  logic                     clk,
    input  logic [$clog2(TOTAL)-2:0] bus_widx,
    input  logic                     bus_we,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    input  logic [$clog2(TOTAL)-1:0] eng_addr,
    input  logic                     eng_we,
    input  logic [7:0]               eng_wdata,
    output logic [7:0]               eng_rdata
);
    localparam int AW = $clog2(TOTAL);

    logic [7:0] mem [TOTAL];

    logic [AW-1:0] lo_idx, hi_idx;
    assign lo_idx = {bus_widx, 1'b0};
    assign hi_idx = {bus_widx, 1'b1};

    always_ff @(posedge clk) begin
        if (bus_we) begin
            mem[lo_idx] <= bus_wdata[7:0];
            mem[hi_idx] <= bus_wdata[15:8];
        end
        if (eng_we) begin
            mem[eng_addr] <= eng_wdata;
        end
    end

    assign bus_rdata = {mem[hi_idx], mem[lo_idx]};
    assign eng_rdata = mem[eng_addr];

    AST_ENG_IN_RANGE: assert property (@(posedge clk)
        eng_we |-> (32'(eng_addr) < 32'(TOTAL))) else $error("engine write outside RAM"); // R5

endmodule

// File: rtl/nand_eng_regs.sv
`timescale 1ns/1ps
module nand_eng_regs
    import nand_eng_pkg::*;
#(
    parameter int BUF_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:1] bus_waddr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    input  logic              busy,
    output logic              reg_hit,
    output logic [15:0]       reg_rdata,
    output logic [BUF_W-1:0]  buf_sel,
    output logic [7:0]        addr_byte,
    output logic [7:0]        cmd_byte,
    output logic              start,
    output op_e               start_op,
    output logic              abort
);
    logic [15:0]      addr_q, cmd_q;
    logic [BUF_W-1:0] sel_q;
    logic [4:0]       ofs;
    logic             ctrl_wr;

    assign reg_hit = (bus_waddr[BUS_AW-1:5] == REG_BASE[BUS_AW-1:5]);
    assign ofs     = {bus_waddr[4:1], 1'b0};
    assign ctrl_wr = bus_we && reg_hit && (ofs == OFS_CTRL);

    assign start_op = decode_trigger({bus_wdata[5], bus_wdata[3:0]});
    assign abort    = ctrl_wr && (bus_wdata == CLEAR_WORD);
    assign start    = ctrl_wr && !abort && !busy && (start_op != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cmd_q  <= '0;
            sel_q  <= '0;
        end else if (bus_we && reg_hit) begin
            case (ofs)
                OFS_ADDR:   addr_q <= bus_wdata;
                OFS_CMD:    cmd_q  <= bus_wdata;
                OFS_BUFSEL: sel_q  <= bus_wdata[BUF_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (ofs)
            OFS_ADDR:   reg_rdata = addr_q;
            OFS_CMD:    reg_rdata = cmd_q;
            OFS_BUFSEL: reg_rdata = 16'(sel_q);
            OFS_CTRL:   reg_rdata[DONE_BIT] = !busy;
            default:    reg_rdata = '0;
        endcase
    end

    assign buf_sel   = sel_q;
    assign addr_byte = addr_q[7:0];
    assign cmd_byte  = cmd_q[7:0];

    AST_CLEAR_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy) else $error("clear word left engine busy"); // R9

endmodule

// File: rtl/nand_eng_seq.sv
`timescale 1ns/1ps
module nand_eng_seq
    import nand_eng_pkg::*;
#(
    parameter int NBUF       = 4,
    parameter int SECT       = 512,
    parameter int SPARE      = 16,
    parameter int STROBE_CYC = 3,
    parameter int BUF_W      = $clog2(NBUF),
    parameter int RAM_AW     = $clog2(NBUF * (SECT + SPARE))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_e               start_op,
    input  logic              abort,
    input  logic [BUF_W-1:0]  buf_sel,
    input  logic [7:0]        addr_byte,
    input  logic [7:0]        cmd_byte,
    output logic              busy,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    input  logic              rb_n_async,
    input  logic [7:0]        io_in,
    output pins_t             pins
);
    localparam int XFER  = SECT + SPARE;
    localparam int IDX_W = $clog2(XFER + 1);
    localparam int CNT_W = $clog2(STROBE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_SECT = IDX_W'(XFER - 1);

    phase_e           phase_q;
    op_e              op_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_last;
    logic [BUF_W-1:0] sel_q;
    logic [7:0]       tx_byte_q;
    logic             rb_s1, rb_s2;
    logic             phase_end;
    int               eff_addr;

    assign idx_last  = (op_q == OP_DIN || op_q == OP_DOUT) ? IDX_SECT : '0;
    assign phase_end = (cnt_q == CNT_LAST);
    assign busy      = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            op_q      <= OP_NONE;
            cnt_q     <= '0;
            idx_q     <= '0;
            sel_q     <= '0;
            tx_byte_q <= '0;
            rb_s1     <= 1'b0;
            rb_s2     <= 1'b0;
        end else begin
            rb_s1 <= rb_n_async;
            rb_s2 <= rb_s1;
            if (abort) begin
                phase_q <= PH_IDLE;
                op_q    <= OP_NONE;
                cnt_q   <= '0;
                idx_q   <= '0;
            end else begin
                case (phase_q)
                    PH_IDLE: begin
                        if (start) begin
                            op_q      <= start_op;
                            sel_q     <= buf_sel;
                            tx_byte_q <= (start_op == OP_CMD) ? cmd_byte : addr_byte;
                            cnt_q     <= '0;
                            idx_q     <= '0;
                            phase_q   <= (start_op == OP_DOUT) ? PH_WAITRB : PH_LOW;
                        end
                    end
                    PH_WAITRB: begin
                        if (rb_s2) phase_q <= PH_LOW;
                    end
                    PH_LOW: begin
                        if (phase_end) begin
                            cnt_q   <= '0;
                            phase_q <= PH_HIGH;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (phase_end) begin
                            cnt_q <= '0;
                            if (idx_q == idx_last) begin
                                phase_q <= PH_IDLE;
                                op_q    <= OP_NONE;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                phase_q <= PH_LOW;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    // byte position inside the sector RAM for the current transfer index
    always_comb begin
        if (op_q == OP_STAT)
            eff_addr = 0;
        else if (int'(idx_q) < SECT)
            eff_addr = int'(sel_q) * SECT + int'(idx_q);
        else
            eff_addr = NBUF * SECT + int'(sel_q) * SPARE + int'(idx_q) - SECT;
        ram_addr = RAM_AW'(eff_addr);
    end

    assign ram_we    = (phase_q == PH_LOW) && phase_end && is_read_op(op_q);
    assign ram_wdata = io_in;

    always_comb begin
        pins.ce_n  = (phase_q == PH_IDLE);
        pins.cle   = (op_q == OP_CMD);
        pins.ale   = (op_q == OP_ADDR);
        pins.we_n  = !((phase_q == PH_LOW) && is_write_op(op_q));
        pins.re_n  = !((phase_q == PH_LOW) && is_read_op(op_q));
        pins.io_oe = is_write_op(op_q);
        case (op_q)
            OP_CMD, OP_ADDR: pins.io = tx_byte_q;
            OP_DIN:          pins.io = ram_rdata;
            default:         pins.io = 8'h00;
        endcase
    end

    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(pins.cle && pins.ale)) else $error("CLE and ALE together"); // R3

    AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!pins.we_n || !pins.re_n) |-> !pins.ce_n) else $error("strobe outside CE frame"); // R11

    AST_IO_HELD: assert property (@(posedge clk) disable iff (rst)
        (!pins.we_n && $past(!pins.we_n) && (op_q == OP_CMD || op_q == OP_ADDR))
        |-> $stable(pins.io)) else $error("I/O moved during write pulse"); // R11

    AST_RB_GATE: assert property (@(posedge clk) disable iff (rst)
        ($fell(pins.re_n) && op_q == OP_DOUT && idx_q == '0) |-> $past(rb_s2))
        else $error("read pulse before ready"); // R5

    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (rst)
        (busy && !abort) |=> (!busy || $stable(op_q))) else $error("operation changed mid-run"); // R8

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (pins.ce_n && pins.we_n && pins.re_n)) else $error("abort left pins active"); // R9

endmodule

// File: rtl/nand_prim_engine.sv
`timescale 1ns/1ps
module nand_prim_engine
    import nand_eng_pkg::*;
#(
    parameter int NBUF       = 4,
    parameter int SECT       = 512,
    parameter int SPARE      = 16,
    parameter int STROBE_CYC = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] bus_addr,
    input  logic        bus_we,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        fl_ce_n,
    output logic        fl_cle,
    output logic        fl_ale,
    output logic        fl_we_n,
    output logic        fl_re_n,
    output logic        fl_io_oe,
    output logic [7:0]  fl_io_out,
    input  logic [7:0]  fl_io_in,
    input  logic        fl_rb_n
);
    localparam int BUF_W  = $clog2(NBUF);
    localparam int TOTAL  = NBUF * (SECT + SPARE);
    localparam int RAM_AW = $clog2(TOTAL);

    logic              ram_hit, reg_hit;
    logic [15:0]       ram_rdata, reg_rdata;
    logic [BUF_W-1:0]  buf_sel;
    logic [7:0]        addr_byte, cmd_byte;
    logic              start, abort, busy;
    op_e               start_op;
    logic [RAM_AW-1:0] eng_addr;
    logic              eng_we;
    logic [7:0]        eng_wdata, eng_rdata;
    pins_t             pins;

    assign ram_hit = (32'(bus_addr) < 32'(TOTAL));

    nand_buf_ram #(.TOTAL(TOTAL)) u_ram (
        .clk       (clk),
        .bus_widx  (bus_addr[RAM_AW-1:1]),
        .bus_we    (bus_we && ram_hit),
        .bus_wdata (bus_wdata),
        .bus_rdata (ram_rdata),
        .eng_addr  (eng_addr),
        .eng_we    (eng_we),
        .eng_wdata (eng_wdata),
        .eng_rdata (eng_rdata)
    );

    nand_eng_regs #(.BUF_W(BUF_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_waddr (bus_addr[BUS_AW-1:1]),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .reg_hit   (reg_hit),
        .reg_rdata (reg_rdata),
        .buf_sel   (buf_sel),
        .addr_byte (addr_byte),
        .cmd_byte  (cmd_byte),
        .start     (start),
        .start_op  (start_op),
        .abort     (abort)
    );

    nand_eng_seq #(
        .NBUF(NBUF), .SECT(SECT), .SPARE(SPARE), .STROBE_CYC(STROBE_CYC),
        .BUF_W(BUF_W), .RAM_AW(RAM_AW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_op   (start_op),
        .abort      (abort),
        .buf_sel    (buf_sel),
        .addr_byte  (addr_byte),
        .cmd_byte   (cmd_byte),
        .busy       (busy),
        .ram_addr   (eng_addr),
        .ram_we     (eng_we),
        .ram_wdata  (eng_wdata),
        .ram_rdata  (eng_rdata),
        .rb_n_async (fl_rb_n),
        .io_in      (fl_io_in),
        .pins       (pins)
    );

    assign bus_rdata = reg_hit ? reg_rdata : (ram_hit ? ram_rdata : 16'h0000);

    assign fl_ce_n   = pins.ce_n;
    assign fl_cle    = pins.cle;
    assign fl_ale    = pins.ale;
    assign fl_we_n   = pins.we_n;
    assign fl_re_n   = pins.re_n;
    assign fl_io_oe  = pins.io_oe;
    assign fl_io_out = pins.io;

endmodule

// File: tb/tb_nand_prim_engine.sv
`timescale 1ns/1ps
module tb_nand_prim_engine;
    localparam int NB  = 4;
    localparam int SE  = 16;
    localparam int SP  = 4;
    localparam int T   = 2;
    localparam int XF  = SE + SP;
    localparam int TOT = NB * XF;

    localparam logic [11:0] A_BSEL = 12'hE04;
    localparam logic [11:0] A_ADR  = 12'hE06;
    localparam logic [11:0] A_CMD  = 12'hE08;
    localparam logic [11:0] A_CTRL = 12'hE1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_io_oe;
    logic [7:0]  fl_io_out;
    logic [7:0]  fl_io_in = '0;
    logic        fl_rb_n = 1'b1;

    int checks = 0;
    int errors = 0;

    nand_prim_engine #(.NBUF(NB), .SECT(SE), .SPARE(SP), .STROBE_CYC(T)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
        .fl_re_n(fl_re_n), .fl_io_oe(fl_io_oe), .fl_io_out(fl_io_out),
        .fl_io_in(fl_io_in), .fl_rb_n(fl_rb_n)
    );

    always #2.5 clk = ~clk;

    // flash model state
    logic       mon_en = 1'b0;
    logic       prev_we = 1'b1, prev_re = 1'b1;
    int         we_cnt = 0, re_cnt = 0, len_w = 0, len_r = 0;
    int         width_err = 0, io_unstable = 0, re_early = 0, oe_err = 0;
    logic [7:0] cap_io  [64];
    logic       cap_cle [64];
    logic       cap_ale [64];
    logic [7:0] hold_io = '0;
    logic [7:0] re_base = '0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (!fl_we_n) begin
                if (prev_we) begin
                    if (we_cnt < 64) begin
                        cap_io[we_cnt]  = fl_io_out;
                        cap_cle[we_cnt] = fl_cle;
                        cap_ale[we_cnt] = fl_ale;
                    end
                    if (!fl_io_oe || fl_ce_n) oe_err++;
                    we_cnt++;
                    hold_io = fl_io_out;
                    len_w = 1;
                end else begin
                    len_w++;
                    if (fl_io_out !== hold_io) io_unstable++;
                end
            end else if (!prev_we) begin
                if (len_w != T) width_err++;
            end
            if (!fl_re_n) begin
                if (prev_re) begin
                    if (!fl_rb_n) re_early++;
                    fl_io_in = re_base + 8'(re_cnt * 5);
                    re_cnt++;
                    len_r = 1;
                end else begin
                    len_r++;
                end
            end else if (!prev_re) begin
                if (len_r != T) width_err++;
            end
            prev_we = fl_we_n;
            prev_re = fl_re_n;
        end
    end

    function automatic logic [7:0] pb(input int a);
        return 8'(a * 7 + 11);
    endfunction

    function automatic int ram_pos(input int b, input int k);
        if (k < SE) return b * SE + k;
        return NB * SE + b * SP + (k - SE);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clr_mon();
        we_cnt = 0; re_cnt = 0; width_err = 0; io_unstable = 0; re_early = 0; oe_err = 0;
    endtask

    task automatic wait_done(input string req);
        logic [15:0] d;
        bit ok = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            bus_read(A_CTRL, d);
            if (d[15]) begin ok = 1; break; end
        end
        if (!ok) chk(req, "done never set", 0, 1);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] keep;
        logic [7:0]  cmds [5];
        logic [15:0] adrs [4];
        bit          cle_seen;
        cmds = '{8'h00, 8'h30, 8'h70, 8'hFF, 8'hA5};
        adrs = '{16'h0000, 16'h1234, 16'hABFF, 16'h0080};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mon_en = 1'b1;

        // R1 reset state
        bus_read(A_CTRL, d);
        chk("R1", "ctrl after reset", d, 16'h8000);
        chk("R1", "pins after reset", {fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_io_oe}, 6'b111000);

        // R10 registers and RAM sweep
        bus_write(A_BSEL, 16'hFFFF);
        bus_read(A_BSEL, d);
        chk("R10", "bufsel masked", d, 16'h0003);
        bus_write(A_ADR, 16'h1234);
        bus_read(A_ADR, d);
        chk("R10", "address reg", d, 16'h1234);
        bus_write(A_CMD, 16'hBEEF);
        bus_read(A_CMD, d);
        chk("R10", "command reg", d, 16'hBEEF);
        for (int a = 0; a < TOT; a += 2) bus_write(12'(a), {pb(a + 1), pb(a)});
        for (int a = 0; a < TOT; a += 2) begin
            @(negedge clk);
            bus_read(12'(a), d);
            chk("R10", $sformatf("ram word %0d", a), d, {pb(a + 1), pb(a)});
        end

        // R2 command cycles, plus R11 done timing on each
        foreach (cmds[i]) begin
            bus_write(A_CMD, {8'h01, cmds[i]});
            clr_mon();
            bus_write(A_CTRL, 16'h0001);
            bus_read(A_CTRL, d);
            chk("R2", "busy right after trigger", d, 16'h0000);
            repeat (2 * T - 1) @(negedge clk);
            bus_read(A_CTRL, d);
            chk("R11", "still busy before last cycle", d, 16'h0000);
            @(negedge clk);
            bus_read(A_CTRL, d);
            chk("R11", "done after 2*T cycles", d, 16'h8000);
            chk("R2", "one WE pulse", we_cnt, 1);
            chk("R2", "command byte", cap_io[0], cmds[i]);
            chk("R2", "CLE/ALE", {cap_cle[0], cap_ale[0]}, 2'b10);
            chk("R11", "widths/frame", width_err + io_unstable + oe_err, 0);
        end

        // R3 address cycles
        foreach (adrs[i]) begin
            bus_write(A_ADR, adrs[i]);
            clr_mon();
            bus_write(A_CTRL, 16'h0002);
            wait_done("R3");
            chk("R3", "one WE pulse", we_cnt, 1);
            chk("R3", "address low byte", cap_io[0], adrs[i][7:0]);
            chk("R3", "CLE/ALE", {cap_cle[0], cap_ale[0]}, 2'b01);
            chk("R11", "widths/frame", width_err + io_unstable + oe_err, 0);
        end

        // R4 data input from every buffer
        for (int b = 0; b < NB; b++) begin
            bus_write(A_BSEL, 16'(b));
            clr_mon();
            bus_write(A_CTRL, 16'h0004);
            wait_done("R4");
            chk("R4", $sformatf("pulses buf %0d", b), we_cnt, XF);
            for (int k = 0; k < XF; k++) begin
                chk("R4", $sformatf("buf %0d byte %0d", b, k), {cap_cle[k], cap_ale[k], cap_io[k]},
                    {2'b00, pb(ram_pos(b, k))});
            end
            chk("R11", "widths", width_err + oe_err, 0);
        end

        // R8 trigger during data input is ignored
        bus_write(A_BSEL, 16'h0001);
        clr_mon();
        bus_write(A_CTRL, 16'h0004);
        repeat (5) @(negedge clk);
        bus_write(A_CTRL, 16'h0001);
        bus_write(A_CTRL, 16'h0008);
        wait_done("R8");
        chk("R8", "pulse count unchanged", we_cnt, XF);
        cle_seen = 0;
        for (int k = 0; k < XF; k++) if (cap_cle[k] || cap_io[k] != pb(ram_pos(1, k))) cle_seen = 1;
        chk("R8", "bytes and CLE unchanged", cle_seen, 0);
        chk("R8", "no read pulses", re_cnt, 0);

        // R5 data output into every buffer, gated by R/B#
        for (int b = 0; b < NB; b++) begin
            bus_write(A_BSEL, 16'(b));
            re_base = 8'h10 + 8'(b * 33);
            fl_rb_n = 1'b0;
            clr_mon();
            bus_write(A_CTRL, 16'h0008);
            repeat (30) @(negedge clk);
            bus_read(A_CTRL, d);
            chk("R5", "waits while R/B# low", {d, 8'(re_cnt)}, 24'h0000_00);
            fl_rb_n = 1'b1;
            wait_done("R5");
            chk("R5", $sformatf("pulses buf %0d", b), re_cnt, XF);
            chk("R5", "no early RE", re_early, 0);
            chk("R11", "RE widths", width_err, 0);
            for (int k = 0; k < XF; k += 2) begin
                @(negedge clk);
                bus_read(12'(ram_pos(b, k)), d);
                chk("R5", $sformatf("buf %0d byte %0d", b, k), d,
                    {re_base + 8'((k + 1) * 5), re_base + 8'(k * 5)});
            end
        end

        // R6 status read goes to byte 0 regardless of select
        @(negedge clk);
        bus_read(12'h000, keep);
        bus_write(A_BSEL, 16'h0003);
        re_base = 8'hC3;
        clr_mon();
        bus_write(A_CTRL, 16'h0020);
        wait_done("R6");
        chk("R6", "one RE pulse", re_cnt, 1);
        bus_read(12'h000, d);
        chk("R6", "status byte at 0x000, 0x001 kept", d, {keep[15:8], 8'hC3});
        bus_read(12'(ram_pos(3, 0)), d);
        chk("R6", "selected buffer untouched", d, {8'h10 + 8'(99) + 8'd5, 8'h10 + 8'(99)});

        // R7 priority and no-trigger writes
        bus_write(A_ADR, 16'h005A);
        clr_mon();
        bus_write(A_CTRL, 16'h002E);
        wait_done("R7");
        chk("R7", "bit1 beats 2,3,5", {8'(we_cnt), 8'(re_cnt), cap_io[0], cap_ale[0]}, {8'd1, 8'd0, 8'h5A, 1'b1});
        bus_write(A_CMD, 16'h0090);
        clr_mon();
        bus_write(A_CTRL, 16'h0003);
        wait_done("R7");
        chk("R7", "bit0 beats bit1", {8'(we_cnt), cap_io[0], cap_cle[0]}, {8'd1, 8'h90, 1'b1});
        clr_mon();
        bus_write(A_CTRL, 16'h4010);
        bus_read(A_CTRL, d);
        chk("R7", "no-trigger write keeps done", d, 16'h8000);
        repeat (20) @(negedge clk);
        chk("R7", "no pulses from no-trigger write", we_cnt + re_cnt, 0);

        // R9 abort a running data output
        bus_write(A_BSEL, 16'h0002);
        clr_mon();
        bus_write(A_CTRL, 16'h0008);
        repeat (12) @(negedge clk);
        bus_write(A_CTRL, 16'h8000);
        bus_read(A_CTRL, d);
        chk("R9", "done after clear", d, 16'h8000);
        chk("R9", "pins released", {fl_ce_n, fl_re_n, fl_we_n}, 3'b111);
        re_cnt = 0;
        repeat (40) @(negedge clk);
        chk("R9", "no strobes after clear", re_cnt + we_cnt, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule